// File: doc/BRIEF.md
# Dual-Reference Selection Controller

This block is the automatic control machine of a clock synchroniser that can lock to one of two timing references. It watches loss-of-signal flags for a primary and a secondary reference and a guard-time input. From these it decides which reference the loop follows and when the loop must go into holdover. It acts only once per frame. A frame-rate strobe (nominally 8 kHz) is brought into the block's clock domain. On each rising edge of the strobe, the three inputs are captured and the machine takes one step.

The guard-time output is the primary loss flag as last captured. The surrounding board feeds it back to the guard-time input through a slow delay network. While the guard-time input is still high, the controller does not return from holdover to the primary reference. The same input, once high, allows the move over to the secondary reference. Four states exist: primary normal, primary holdover, secondary normal and secondary holdover. Reset enters primary normal.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is asserted, ref_sel, holdover and guard_out are all 0 and the machine is in primary normal.
- R2: Changes on pri_loss, sec_loss or guard_in that occur with no frame strobe rising edge leave ref_sel, holdover and guard_out unchanged.
- R3: After every frame strobe rising edge, guard_out equals the pri_loss level captured at that edge.
- R4: In primary normal, a captured pri_loss of 1 moves to primary holdover (holdover=1, ref_sel=0). A captured pri_loss of 0 keeps primary normal.
- R5: In primary holdover, captured pri_loss=0 together with guard_in=0 returns to primary normal (holdover=0, ref_sel=0).
- R6: In primary holdover, captured pri_loss=0 with guard_in=1 keeps primary holdover.
- R7: In primary holdover, captured pri_loss=1, guard_in=1 and sec_loss=0 move to secondary normal (ref_sel=1, holdover=0).
- R8: In primary holdover, captured pri_loss=1 with either guard_in=0 or sec_loss=1 keeps primary holdover.
- R9: In secondary normal, captured pri_loss=0 returns to primary normal, whatever sec_loss is.
- R10: In secondary normal, captured pri_loss=1 with sec_loss=1 moves to secondary holdover (ref_sel=1, holdover=1). With sec_loss=0 it stays in secondary normal.
- R11: In secondary holdover, captured pri_loss=0 returns to primary normal. Captured pri_loss=1 with sec_loss=0 returns to secondary normal. Otherwise the state holds.
- R12: ref_sel is 1 exactly in the two secondary states and holdover is 1 exactly in the two holdover states. Both change only in the cycle after a frame strobe rising edge has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strobe | input | 1 | Frame-rate sampling strobe, asynchronous to clk |
| pri_loss | input | 1 | Primary reference lost when 1 |
| sec_loss | input | 1 | Secondary reference lost or invalid when 1 |
| guard_in | input | 1 | Guard-time input from the external delay network |
| ref_sel | output | 1 | Selected reference: 0 primary, 1 secondary |
| holdover | output | 1 | 1 while in a holdover state |
| guard_out | output | 1 | Captured primary loss, to drive the delay network |

## Verification
The two state bits appear directly on ref_sel and holdover. A wrong next-state therefore shows at the ports one cycle after the captured strobe, and a wrong state stays visible until the next frame. A fault in the guard condition shows only in primary holdover, so the stimulus drives each pri_loss and guard_in pair there. It also runs the board's delay loop, where guard_in lags guard_out by one frame. A capture taken outside the strobe edge shows as an output that moves during a frame with no strobe.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    ST_PRI_NORM = 2'd0,
    ST_PRI_HOLD = 2'd1,
    ST_SEC_NORM = 2'd2,
    ST_SEC_HOLD = 2'd3
  } refsel_state_t;

  // one frame step of the selection machine
  function automatic refsel_state_t refsel_step(input refsel_state_t cur,
                                                input logic pri_lost,
                                                input logic sec_lost,
                                                input logic guard_hi);
    refsel_state_t nxt;
    nxt = cur;
    unique case (cur)
      ST_PRI_NORM: if (pri_lost) nxt = ST_PRI_HOLD;
      ST_PRI_HOLD: begin
        if (!pri_lost && !guard_hi)                nxt = ST_PRI_NORM;
        else if (pri_lost && guard_hi && !sec_lost) nxt = ST_SEC_NORM;
      end
      ST_SEC_NORM: begin
        if (!pri_lost)    nxt = ST_PRI_NORM;
        else if (sec_lost) nxt = ST_SEC_HOLD;
      end
      ST_SEC_HOLD: begin
        if (!pri_lost)     nxt = ST_PRI_NORM;
        else if (!sec_lost) nxt = ST_SEC_NORM;
      end
      default: nxt = ST_PRI_NORM;
    endcase
    return nxt;
  endfunction

  function automatic logic refsel_is_hold(input refsel_state_t st);
    return (st == ST_PRI_HOLD) || (st == ST_SEC_HOLD);
  endfunction

  function automatic logic refsel_is_sec(input refsel_state_t st);
    return (st == ST_SEC_NORM) || (st == ST_SEC_HOLD);
  endfunction

endpackage

// File: rtl/refsel_strobe_edge.sv
module refsel_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic strobe_rise
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= strobe_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];

  assign strobe_rise = sync_q[LAST] & ~prev_q;

endmodule

// File: rtl/refsel_capture.sv
module refsel_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic pri_in,
  input  logic sec_in,
  input  logic guard_in,
  output logic cap_valid,
  output logic cap_pri,
  output logic cap_sec,
  output logic cap_guard
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_pri   <= 1'b0;
      cap_sec   <= 1'b0;
      cap_guard <= 1'b0;
    end else begin
      cap_valid <= take;
      if (take) begin
        cap_pri   <= pri_in;
        cap_sec   <= sec_in;
        cap_guard <= guard_in;
      end
    end
  end
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic pri_lost,
  input  logic sec_lost,
  input  logic guard_hi,
  output logic ref_sel,
  output logic holdover
);
  refsel_state_t state_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    state_q <= ST_PRI_NORM;
    else if (step) state_q <= refsel_step(state_q, pri_lost, sec_lost, guard_hi);

  assign ref_sel  = refsel_is_sec(state_q);
  assign holdover = refsel_is_hold(state_q);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_strobe,
  input  logic pri_loss,
  input  logic sec_loss,
  input  logic guard_in,
  output logic ref_sel,
  output logic holdover,
  output logic guard_out
);
  logic strobe_rise;
  logic cap_valid;
  logic cap_pri;
  logic cap_sec;
  logic cap_guard;

  refsel_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_in  (frame_strobe),
    .strobe_rise(strobe_rise)
  );

  refsel_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (strobe_rise),
    .pri_in   (pri_loss),
    .sec_in   (sec_loss),
    .guard_in (guard_in),
    .cap_valid(cap_valid),
    .cap_pri  (cap_pri),
    .cap_sec  (cap_sec),
    .cap_guard(cap_guard)
  );

  refsel_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (cap_valid),
    .pri_lost(cap_pri),
    .sec_lost(cap_sec),
    .guard_hi(cap_guard),
    .ref_sel (ref_sel),
    .holdover(holdover)
  );

  assign guard_out = cap_pri;
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_rise,
  input logic cap_valid,
  input logic cap_pri,
  input logic cap_sec,
  input logic cap_guard,
  input logic pri_loss,
  input logic ref_sel,
  input logic holdover,
  input logic guard_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!ref_sel && !holdover && !guard_out));

  // R2
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_rise |=> $stable(guard_out));

  // R12
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |=> ($stable(ref_sel) && $stable(holdover)));

  // R3
  guard_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_rise |=> (guard_out == $past(pri_loss)));

  // R4
  enter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !ref_sel && !holdover && cap_pri) |=> (holdover && !ref_sel));

  // R7
  to_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !ref_sel && holdover && cap_pri && cap_guard && !cap_sec)
      |=> (ref_sel && !holdover));

  // R6
  guard_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !ref_sel && holdover && !cap_pri && cap_guard)
      |=> (holdover && !ref_sel));

  // R10
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && ref_sel && !holdover && cap_pri && cap_sec)
      |=> (ref_sel && holdover));

  // R9
  sec_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && ref_sel && !cap_pri) |=> (!ref_sel && !holdover));
endmodule

bind refsel_ctrl refsel_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_rise(strobe_rise),
  .cap_valid  (cap_valid),
  .cap_pri    (cap_pri),
  .cap_sec    (cap_sec),
  .cap_guard  (cap_guard),
  .pri_loss   (pri_loss),
  .ref_sel    (ref_sel),
  .holdover   (holdover),
  .guard_out  (guard_out)
);

// File: tb/refsel_ctrl_bench.sv
`timescale 1ns/1ps
module refsel_ctrl_bench;
  localparam int RC_DLY  = 10;
  localparam int HALF_FR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_strobe = 1'b0;
  logic pri_loss = 1'b0;
  logic sec_loss = 1'b0;
  logic guard_drv = 1'b0;
  logic use_rc = 1'b0;
  logic guard_in;
  logic ref_sel, holdover, guard_out;
  logic [RC_DLY-1:0] rc_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] m_st = 2'b00;   // {secondary side, in holdover}
  logic       m_gout = 1'b0;

  logic [2:0] q_vals[$];
  string      q_tags[$];
  event       chk_ev;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rc_line <= '0;
    else        rc_line <= {rc_line[RC_DLY-2:0], guard_out};

  assign guard_in = use_rc ? rc_line[RC_DLY-1] : guard_drv;

  refsel_ctrl u_refsel_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
    .pri_loss(pri_loss), .sec_loss(sec_loss), .guard_in(guard_in),
    .ref_sel(ref_sel), .holdover(holdover), .guard_out(guard_out)
  );

  function automatic logic [1:0] model(input logic [1:0] st, input logic p,
                                       input logic s, input logic g);
    case (st)
      2'b00:   return p ? 2'b01 : 2'b00;
      2'b01:   return (!p && !g) ? 2'b00 : ((p && g && !s) ? 2'b10 : 2'b01);
      2'b10:   return !p ? 2'b00 : (s ? 2'b11 : 2'b10);
      default: return !p ? 2'b00 : (!s ? 2'b10 : 2'b11);
    endcase
  endfunction

  task automatic push_and_wait(input string tag);
    q_vals.push_back({m_st[1], m_st[0], m_gout});
    q_tags.push_back(tag);
    -> chk_ev;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic p, input logic s, input logic g, input string tag);
    logic gs;
    @(negedge clk);
    pri_loss = p; sec_loss = s; guard_drv = g;
    gs = use_rc ? m_gout : g;
    m_st = model(m_st, p, s, gs);
    m_gout = p;
    frame_strobe = 1'b1;
    repeat (HALF_FR) @(negedge clk);
    frame_strobe = 1'b0;
    repeat (HALF_FR) @(negedge clk);
    push_and_wait(tag);
  endtask

  task automatic quiet_change(input logic p, input logic s, input logic g, input string tag);
    @(negedge clk);
    pri_loss = p; sec_loss = s; guard_drv = g;
    repeat (2 * HALF_FR) @(negedge clk);
    push_and_wait(tag);
  endtask

  initial begin : monitor
    logic [2:0] exp_v, got_v;
    string tag;
    forever begin
      @(chk_ev);
      @(negedge clk);
      exp_v = q_vals.pop_front();
      tag   = q_tags.pop_front();
      got_v = {ref_sel, holdover, guard_out};
      checks++;
      if (got_v !== exp_v) begin
        errors++;
        $display("FAIL %s: {ref_sel,holdover,guard_out} actual %b expected %b", tag, got_v, exp_v);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    push_and_wait("R1 reset state");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    frame(0, 0, 0, "R4 stay primary normal");
    quiet_change(1, 1, 1, "R2 no strobe no change");
    frame(1, 0, 0, "R4 enter primary holdover, R3 guard_out");
    frame(1, 0, 0, "R8 guard low holds");
    frame(1, 1, 1, "R8 secondary lost holds");
    frame(0, 0, 1, "R6 guard high blocks return");
    frame(0, 0, 0, "R5 return primary normal");
    frame(1, 0, 0, "R4 holdover again");
    frame(1, 0, 1, "R7 to secondary normal");
    quiet_change(0, 1, 0, "R2 no strobe in secondary");
    frame(1, 0, 1, "R10 stay secondary normal");
    frame(1, 1, 0, "R10 secondary holdover");
    frame(1, 1, 1, "R11 stay secondary holdover");
    frame(1, 0, 0, "R11 back to secondary normal");
    frame(1, 1, 0, "R10 secondary holdover again");
    frame(0, 1, 0, "R11 to primary normal, R12");
    frame(1, 0, 0, "R4 holdover");
    frame(1, 0, 1, "R7 secondary");
    frame(0, 1, 0, "R9 primary clears");

    use_rc = 1'b1;
    frame(1, 0, 0, "R4 loop holdover");
    frame(1, 0, 0, "R7 loop guard to secondary");
    frame(0, 0, 0, "R9 loop return");
    frame(1, 0, 0, "R4 loop holdover");
    frame(0, 0, 0, "R6 loop guard still high");
    frame(0, 0, 0, "R5 loop guard low return");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule